// File: doc/BRIEF.md
# Subtract-Based Condition Evaluator

This block compares two unsigned 8-bit operands and produces one Boolean result. It does this with a single adder pass. The adder computes the operand A plus the bitwise inverse of B with no carry injected, which is A minus B minus 1. From that one result it derives the relation picked by a 3-bit condition code.

- Equality is recognised when the difference is all ones.
- "Greater than" is the carry out of the most significant slice.
- The other four relations are built from those two facts.

The adder is made of cascaded 4-bit slices, the same way a byte-wide arithmetic unit is built from nibble units.

Operands and condition enter through a valid/ready handshake, and the flag leaves through a second one. With the default output register the block holds one result:

- `in_ready` is high when the output stage is empty or the consumer is taking its result in the same cycle.
- A result that is presented but not taken stays unchanged until `out_ready` is seen high.

A producer holds its inputs while `in_valid` is high and `in_ready` is low. With the output register disabled, the path is purely combinational and the handshakes pass straight through.

Top module: `subcmp_eval`

## Requirements
- R1: Condition code 0 (equal) yields a flag of 1 exactly when A equals B.
- R2: Condition code 1 (not equal) yields 1 exactly when A differs from B.
- R3: Condition code 2 (less than, unsigned) yields 1 exactly when A < B.
- R4: Condition code 3 (greater than, unsigned) yields 1 exactly when A > B.
- R5: Condition code 4 (less or equal, unsigned) yields 1 exactly when A <= B.
- R6: Condition code 5 (greater or equal, unsigned) yields 1 exactly when A >= B.
- R7: Condition codes 6 and 7 always yield a flag of 0.
- R8: With the output register enabled, an input accepted on a clock edge (in_valid and in_ready both high) is presented as out_valid with its flag right after that edge. A presented result whose out_ready is low stays valid with an unchanged flag.
- R9: in_ready is low exactly while a result is held and out_ready is low. No new input is taken then.
- R10: After reset, out_valid is 0.
- R11: With out_ready held high, a new input is accepted on every clock, giving one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and condition are present |
| in_ready | output | 1 | Block can take the presented operands |
| a_i | input | WIDTH | First operand (A) |
| b_i | input | WIDTH | Second operand (B) |
| cond_i | input | 3 | Relation select: 0 EQ, 1 NE, 2 LT, 3 GT, 4 LE, 5 GE, 6/7 false |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_flag | output | 1 | Boolean result of the selected relation |

## Verification
With the output register enabled, every flag is due in the cycle after the edge that accepted its operands. It stays due until the edge on which out_ready is seen high.

The bench drives inputs and samples outputs at the falling edge. Each sample is taken after one rising edge has moved both the design and a queue-based reference model. At that point the head of the queue is compared with out_valid, out_flag and in_ready.

Directed vectors cover the operand extremes 0 and 255 and the adjacent pairs on either side of equality. Stall phases cover the hold rule, and random traffic covers the rest.

// File: rtl/subcmp_pkg.sv
package subcmp_pkg;

  typedef enum logic [2:0] {
    CND_EQ  = 3'd0,
    CND_NE  = 3'd1,
    CND_LT  = 3'd2,
    CND_GT  = 3'd3,
    CND_LE  = 3'd4,
    CND_GE  = 3'd5,
    CND_RS6 = 3'd6,
    CND_RS7 = 3'd7
  } cond_e;

  // Relation summary extracted from one A + ~B pass
  typedef struct packed {
    logic eq;
    logic gt;
  } rel_t;

endpackage

// File: rtl/subcmp_slice.sv
// One nibble-style adder slice: computes x + ~y + cin.
module subcmp_slice #(
  parameter int SLICE = 4
) (
  input  logic [SLICE-1:0] x,
  input  logic [SLICE-1:0] y,
  input  logic             cin,
  output logic [SLICE-1:0] sum,
  output logic             cout
);
  logic [SLICE:0] total;

  always_comb begin
    total = {1'b0, x} + {1'b0, ~y} + {{SLICE{1'b0}}, cin};
    sum   = total[SLICE-1:0];
    cout  = total[SLICE];
  end
endmodule

// File: rtl/subcmp_chain.sv
// Cascade of slices forming A - B - 1 (carry-in held low).
module subcmp_chain #(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] diff,
  output logic             carry
);
  localparam int NSLICE = WIDTH / SLICE;

  logic [NSLICE:0] c;

  assign c[0] = 1'b0;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    subcmp_slice #(.SLICE(SLICE)) u_slice (
      .x   (a[s*SLICE +: SLICE]),
      .y   (b[s*SLICE +: SLICE]),
      .cin (c[s]),
      .sum (diff[s*SLICE +: SLICE]),
      .cout(c[s+1])
    );
  end

  assign carry = c[NSLICE];
endmodule

// File: rtl/subcmp_decode.sv
// Maps the difference and carry onto the selected relation.
module subcmp_decode
  import subcmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] diff,
  input  logic             carry,
  input  logic [2:0]       cond,
  output logic             flag
);
  rel_t  rel;
  cond_e sel;

  always_comb begin
    rel.eq = &diff;
    rel.gt = carry;
    sel    = cond_e'(cond);
    case (sel)
      CND_EQ:  flag = rel.eq;
      CND_NE:  flag = ~rel.eq;
      CND_LT:  flag = ~(rel.gt | rel.eq);
      CND_GT:  flag = rel.gt;
      CND_LE:  flag = ~rel.gt;
      CND_GE:  flag = rel.gt | rel.eq;
      default: flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/subcmp_ostage.sv
// Output stage: one-entry register with valid/ready, or a pass-through.
module subcmp_ostage #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic flag_d,
  output logic out_valid,
  input  logic out_ready,
  output logic out_flag
);
  if (REG_OUT) begin : g_reg
    logic vld_q;
    logic flg_q;

    assign in_ready = ~vld_q | out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        flg_q <= 1'b0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) flg_q <= flag_d;
      end
    end

    assign out_valid = vld_q;
    assign out_flag  = flg_q;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_flag   = flag_d;
  end
endmodule

// File: rtl/subcmp_eval.sv
module subcmp_eval #(
  parameter int WIDTH   = 8,
  parameter int SLICE   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       cond_i,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_flag
);
  logic [WIDTH-1:0] diff;
  logic             carry;
  logic             flag_c;

  subcmp_chain #(.WIDTH(WIDTH), .SLICE(SLICE)) u_chain (
    .a    (a_i),
    .b    (b_i),
    .diff (diff),
    .carry(carry)
  );

  subcmp_decode #(.WIDTH(WIDTH)) u_dec (
    .diff (diff),
    .carry(carry),
    .cond (cond_i),
    .flag (flag_c)
  );

  subcmp_ostage #(.REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .flag_d   (flag_c),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_flag (out_flag)
  );
endmodule

// File: rtl/subcmp_eval_chk.sv
module subcmp_eval_chk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       cond_i,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_flag
);
  if (REG_OUT) begin : g_chk
    // R1
    eq_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && cond_i == 3'd0) |=> (out_flag == ($past(a_i) == $past(b_i))));

    // R4
    gt_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && cond_i == 3'd3) |=> (out_flag == ($past(a_i) > $past(b_i))));

    // R7
    spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && cond_i[2:1] == 2'b11) |=> !out_flag);

    // R8
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_flag)));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

    // R11
    drain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);

    // R10
    reset_empty_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> !out_valid);
  end
endmodule

bind subcmp_eval subcmp_eval_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .a_i      (a_i),
  .b_i      (b_i),
  .cond_i   (cond_i),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_flag (out_flag)
);

// File: tb/subcmp_eval_test.sv
`timescale 1ns/1ps
module subcmp_eval_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] a_i = '0;
  logic [7:0] b_i = '0;
  logic [2:0] cond_i = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_flag;

  int checks = 0;
  int errors = 0;

  bit    flag_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  subcmp_eval uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_i(a_i), .b_i(b_i), .cond_i(cond_i),
    .out_valid(out_valid), .out_ready(out_ready), .out_flag(out_flag)
  );

  function automatic bit ref_flag(int a, int b, int c);
    case (c)
      0: return a == b;
      1: return a != b;
      2: return a < b;
      3: return a > b;
      4: return a <= b;
      5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare outputs with the model, then drive new inputs and advance the model.
  task automatic step(bit v, int a, int b, int c, bit rdy);
    bit mvalid;
    bit acc;
    bit pop;
    @(negedge clk);
    mvalid = flag_q.size() != 0;
    chk("R8", out_valid, mvalid);
    if (mvalid) chk(tag_q[0], out_flag, flag_q[0]);
    in_valid  = v;
    a_i       = a[7:0];
    b_i       = b[7:0];
    cond_i    = c[2:0];
    out_ready = rdy;
    #0.1;
    chk("R9", in_ready, (!mvalid || rdy) ? 1 : 0);
    pop = mvalid && rdy;
    acc = v && (!mvalid || rdy);
    if (pop) begin
      void'(flag_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (acc) begin
      flag_q.push_back(ref_flag(a, b, c));
      tag_q.push_back(tag_of(c));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: the output stage is empty while and after reset
    chk("R10", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", out_valid, 0);

    // Directed boundary operands across all eight codes, R1..R7
    for (int c = 0; c < 8; c++) begin
      step(1, 0, 0, c, 1);
      step(1, 255, 255, c, 1);
      step(1, 255, 0, c, 1);
      step(1, 0, 255, c, 1);
      step(1, 100, 101, c, 1);
      step(1, 101, 100, c, 1);
      step(1, 128, 127, c, 1);
      step(1, 15, 16, c, 1);
    end

    // R8/R9: stall with a held result, the producer keeps offering new data
    step(1, 7, 7, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 3, 9, 3, 0);
    step(1, 3, 9, 3, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    // R11: back-to-back with the consumer always ready
    for (int i = 0; i < 64; i++) begin
      step(1, i * 4, 255 - i * 3, i % 6, 1);
      chk("R11", in_ready, 1);
    end

    // Random traffic with random back-pressure
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 7), $urandom_range(0, 3) != 0);

    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule